// File: doc/BRIEF.md
# PHY Management Access Engine

This block lets a host reach the management registers of an external Ethernet PHY through four byte-wide registers. The host writes a PHY number and a register number into an address register. For a write it also loads a 16-bit value into a low data byte and a high data byte. It then sets a start bit in the control register. The engine shifts a complete serial management frame out on the MDC/MDIO pins and keeps a busy bit set for as long as the frame runs.

On a read, the engine releases the data line at the turnaround and samples the sixteen data bits that the PHY returns. It writes the result into the same two data registers, so the value can be read as soon as busy clears. The control register also has a target-select bit. When that bit is clear, the other target is selected, which this engine does not implement, and a start command is accepted without any effect.

Top module: `phy_mgmt_engine`

## Requirements
- R1: After reset, all four host registers read 0x00, MDC is low and the MDIO output enable is low.
- R2: Host register offsets are 0 = control, 1 = address, 2 = data low byte, 3 = data high byte.
  - The address and data registers read back what was last written.
  - Control reads back bits 3:1 as last accepted, bit 0 as the busy flag, and bits 7:4 as zero.
- R3: Every frame is 64 MDC cycles, sent most significant bit first.
  - It starts with 32 ones, then the start pattern 01.
  - The opcode follows: 10 for a read, 01 for a write.
- R4: After the opcode, the frame carries five PHY-number bits and then five register bits.
  - The PHY-number bits are address bits 7:6, zero-extended.
  - The register bits are address bits 4:0. Address bit 5 is not sent.
  - A write then drives turnaround 10 and the data, high byte bit 7 first.
- R5: A read drives MDIO for the first 46 bit times only. Output enable is low from the turnaround to the end of the frame.
- R6: On a read, the 16 bits sampled on the last 16 rising MDC edges (first bit = bit 15) appear in the data registers (high register = bits 15:8) in the same cycle busy returns to 0.
- R7: Busy reads 1 from the clock after the control write that starts a transaction, and stays 1 for exactly 128 × MDC_HALF_DIV clock cycles.
- R8: A control write while busy is 1 is ignored. No new frame starts, and control bits 3:1 keep their value.
- R9: A start with control bit 3 clear does nothing: busy stays 0 and MDC does not toggle. Bit 3 = 1 selects the PHY target, bit 2 requests a read, bit 1 requests a write.
- R10: MDC is low when idle, and each half period lasts MDC_HALF_DIV clock cycles. MDIO output changes only at falling MDC edges, and input is sampled at rising edges.
- R11: If the read and write bits are both set with bit 3, the engine performs a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | 2 | Host register offset |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data (combinational on host_addr) |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | Management data output |
| mdio_oe | output | 1 | Management data output enable |
| mdio_in | input | 1 | Management data input |

## Verification
A control write is taken at clock edge E0. Busy shows on the next cycle, and MDC first rises MDC_HALF_DIV cycles after E0. Busy falls at E0 + 128 × MDC_HALF_DIV, and a read result is in the data registers at that same edge. The bench records the cycle number right after the start write and polls busy between clock edges, so the elapsed count must equal 128 × MDC_HALF_DIV exactly. The expected frames are queued by the driver and compared bit by bit when the 64th rising MDC edge has been collected. Read data is checked at the first sample point where busy is low.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;

    localparam int FRAME_BITS = 64;
    localparam int TA_FIRST   = 46;
    localparam int DATA_FIRST = 48;
    localparam int IDX_W      = $clog2(FRAME_BITS);

    typedef enum logic [1:0] {
        HREG_CTRL = 2'd0,
        HREG_ADDR = 2'd1,
        HREG_DLO  = 2'd2,
        HREG_DHI  = 2'd3
    } host_reg_e;

    localparam int CB_BUSY = 0;
    localparam int CB_WR   = 1;
    localparam int CB_RD   = 2;
    localparam int CB_PHY  = 3;

    typedef struct packed {
        logic        is_read;
        logic [4:0]  phy;
        logic [4:0]  regad;
        logic [15:0] wdata;
    } mgmt_cmd_t;

    function automatic logic [FRAME_BITS-1:0] build_frame(input mgmt_cmd_t c);
        logic [1:0]  op;
        logic [1:0]  ta;
        logic [15:0] dat;
        op  = c.is_read ? 2'b10 : 2'b01;
        ta  = c.is_read ? 2'b11 : 2'b10;
        dat = c.is_read ? 16'hFFFF : c.wdata;
        return {32'hFFFF_FFFF, 2'b01, op, c.phy, c.regad, ta, dat};
    endfunction

endpackage

// File: rtl/mgmt_regs.sv
module mgmt_regs
    import phy_mgmt_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        host_we,
    input  logic [1:0]  host_addr,
    input  logic [7:0]  host_wdata,
    output logic [7:0]  host_rdata,
    input  logic        busy,
    input  logic        rd_done,
    input  logic [15:0] rd_result,
    output logic        start,
    output mgmt_cmd_t   cmd
);

    logic [3:1] ctrl_q;
    logic [7:0] addr_q;
    logic [7:0] dlo_q;
    logic [7:0] dhi_q;
    logic       ctrl_wr;

    assign ctrl_wr = host_we && (host_addr == HREG_CTRL) && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            addr_q <= '0;
            dlo_q  <= '0;
            dhi_q  <= '0;
        end else begin
            if (ctrl_wr)
                ctrl_q <= host_wdata[3:1];
            if (host_we && host_addr == HREG_ADDR)
                addr_q <= host_wdata;
            if (host_we && host_addr == HREG_DLO)
                dlo_q <= host_wdata;
            if (host_we && host_addr == HREG_DHI)
                dhi_q <= host_wdata;
            if (rd_done) begin
                dlo_q <= rd_result[7:0];
                dhi_q <= rd_result[15:8];
            end
        end
    end

    assign start = ctrl_wr && host_wdata[CB_PHY]
                 && (host_wdata[CB_RD] || host_wdata[CB_WR]);

    always_comb begin
        cmd.is_read = host_wdata[CB_RD];
        cmd.phy     = {3'b000, addr_q[7:6]};
        cmd.regad   = addr_q[4:0];
        cmd.wdata   = {dhi_q, dlo_q};
    end

    always_comb begin
        unique case (host_reg_e'(host_addr))
            HREG_CTRL: host_rdata = {4'b0000, ctrl_q, busy};
            HREG_ADDR: host_rdata = addr_q;
            HREG_DLO:  host_rdata = dlo_q;
            HREG_DHI:  host_rdata = dhi_q;
            default:   host_rdata = 8'h00;
        endcase
    end

endmodule

// File: rtl/mdc_divider.sv
module mdc_divider #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic mdc,
    output logic rise_tick,
    output logic fall_tick
);

    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic [CW-1:0] cnt;
    logic          wrap;

    assign wrap      = run && (cnt == CW'(HALF_DIV - 1));
    assign rise_tick = wrap && !mdc;
    assign fall_tick = wrap && mdc;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (wrap) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/mdio_shifter.sv
module mdio_shifter
    import phy_mgmt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  mgmt_cmd_t        cmd,
    input  logic             rise_tick,
    input  logic             fall_tick,
    input  logic             mdio_in,
    output logic             busy,
    output logic             rd_active,
    output logic [IDX_W-1:0] bit_idx,
    output logic             mdio_out,
    output logic             mdio_oe,
    output logic             rd_done,
    output logic [15:0]      rd_result
);

    logic [FRAME_BITS-1:0] frame_q;
    logic [15:0]           shreg;
    logic                  last_bit;

    assign last_bit = (bit_idx == IDX_W'(FRAME_BITS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy      <= 1'b0;
            rd_active <= 1'b0;
            bit_idx   <= '0;
            frame_q   <= '0;
            shreg     <= '0;
        end else if (start) begin
            busy      <= 1'b1;
            rd_active <= cmd.is_read;
            bit_idx   <= '0;
            frame_q   <= build_frame(cmd);
        end else if (busy) begin
            if (rise_tick && rd_active && bit_idx >= IDX_W'(DATA_FIRST))
                shreg <= {shreg[14:0], mdio_in};
            if (fall_tick) begin
                if (last_bit)
                    busy <= 1'b0;
                else
                    bit_idx <= bit_idx + 1'b1;
            end
        end
    end

    assign mdio_out  = busy ? frame_q[IDX_W'(FRAME_BITS - 1) - bit_idx] : 1'b1;
    assign mdio_oe   = busy && !(rd_active && bit_idx >= IDX_W'(TA_FIRST));
    assign rd_done   = busy && fall_tick && last_bit && rd_active;
    assign rd_result = shreg;

endmodule

// File: rtl/phy_mgmt_engine.sv
module phy_mgmt_engine
    import phy_mgmt_pkg::*;
#(
    parameter int MDC_HALF_DIV = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       host_we,
    input  logic [1:0] host_addr,
    input  logic [7:0] host_wdata,
    output logic [7:0] host_rdata,
    output logic       mdc,
    output logic       mdio_out,
    output logic       mdio_oe,
    input  logic       mdio_in
);

    logic             busy;
    logic             start;
    logic             rd_active;
    logic             rd_done;
    logic [15:0]      rd_result;
    logic [IDX_W-1:0] bit_idx;
    logic             rise_tick;
    logic             fall_tick;
    mgmt_cmd_t        cmd;

    mgmt_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .busy       (busy),
        .rd_done    (rd_done),
        .rd_result  (rd_result),
        .start      (start),
        .cmd        (cmd)
    );

    mdc_divider #(.HALF_DIV(MDC_HALF_DIV)) u_div (
        .clk       (clk),
        .rst       (rst),
        .run       (busy),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    mdio_shifter u_shift (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .cmd       (cmd),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick),
        .mdio_in   (mdio_in),
        .busy      (busy),
        .rd_active (rd_active),
        .bit_idx   (bit_idx),
        .mdio_out  (mdio_out),
        .mdio_oe   (mdio_oe),
        .rd_done   (rd_done),
        .rd_result (rd_result)
    );

endmodule

// File: rtl/phy_mgmt_engine_chk.sv
module phy_mgmt_engine_chk
    import phy_mgmt_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             host_we,
    input logic [1:0]       host_addr,
    input logic [7:0]       host_wdata,
    input logic             busy,
    input logic             start,
    input logic             mdc,
    input logic             mdio_oe,
    input logic [IDX_W-1:0] bit_idx
);

    p_start_idle_r8: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy);

    p_mdc_idle_low_r10: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mdc);

    p_busy_full_frame_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> ($past(bit_idx) == IDX_W'(FRAME_BITS - 1)));

    p_other_target_idle_r9: assert property (@(posedge clk) disable iff (rst)
        (host_we && host_addr == 2'd0 && !host_wdata[3] && !busy) |=> !busy);

    p_first_bit_driven_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (mdio_oe && !mdc));

endmodule

bind phy_mgmt_engine phy_mgmt_engine_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .host_we    (host_we),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .busy       (busy),
    .start      (start),
    .mdc        (mdc),
    .mdio_oe    (mdio_oe),
    .bit_idx    (bit_idx)
);

// File: tb/phy_mgmt_engine_tb.sv
module phy_mgmt_engine_tb;

    localparam int HALF = 2;
    localparam int TXN_CYC = 128 * HALF;

    typedef struct {
        logic [63:0] bits;
        logic [63:0] oe;
        logic [63:0] care;
        string       tag;
    } exp_frame_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       host_we = 1'b0;
    logic [1:0] host_addr = 2'd0;
    logic [7:0] host_wdata = 8'h00;
    logic [7:0] host_rdata;
    logic       mdc, mdio_out, mdio_oe, mdio_in;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int rise_cnt = 0;
    int frames_seen = 0;
    int total_rises = 0;
    logic [15:0] resp_word = 16'h0000;
    logic [63:0] got_bits, got_oe;
    time t_rise;
    exp_frame_t exp_q[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    phy_mgmt_engine #(.MDC_HALF_DIV(HALF)) u_dut (
        .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .mdc(mdc),
        .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in)
    );

    assign mdio_in = (rise_cnt >= 48 && rise_cnt < 64) ? resp_word[15 - (rise_cnt - 48)] : 1'b1;

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Monitor: collects a frame on rising MDC edges and compares with the scoreboard
    always @(posedge mdc) begin
        got_bits[63 - rise_cnt] = mdio_out;
        got_oe[63 - rise_cnt]   = mdio_oe;
        t_rise = $time;
        total_rises++;
        rise_cnt = rise_cnt + 1;
        if (rise_cnt == 64) begin
            rise_cnt = 0;
            frames_seen++;
            if (exp_q.size() == 0) begin
                check(1'b0, "R8 unexpected frame", got_bits, 64'h0);
            end else begin
                exp_frame_t e;
                e = exp_q.pop_front();
                check((got_bits & e.care) == (e.bits & e.care), {e.tag, " frame bits"},
                      got_bits & e.care, e.bits & e.care);
                check(got_oe == e.oe, "R5 output enable pattern", got_oe, e.oe);
            end
        end
    end

    // R10: first high half period of each frame lasts HALF clocks
    always @(negedge mdc) begin
        if (rise_cnt == 1)
            check(($time - t_rise) == HALF * 8, "R10 mdc half period",
                  64'($time - t_rise), 64'(HALF * 8));
    end

    task automatic host_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic host_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        host_addr = a;
        #1 d = host_rdata;
    endtask

    function automatic exp_frame_t make_exp(input bit rd, input logic [7:0] addr, input logic [15:0] wd, input string tag);
        exp_frame_t e;
        e.bits = {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), 3'b000, addr[7:6], addr[4:0],
                  (rd ? 2'b11 : 2'b10), (rd ? 16'h0000 : wd)};
        e.oe   = rd ? ~64'h3FFFF : ~64'h0;
        e.care = rd ? ~64'h3FFFF : ~64'h0;
        e.tag  = tag;
        return e;
    endfunction

    // Driver: pushes the expected frame, loads registers, starts the transaction
    task automatic start_txn(input bit rd, input logic [7:0] addr, input logic [15:0] wd,
                             input logic [15:0] rsp, input logic [7:0] ctrl, input string tag,
                             output int start_cyc);
        exp_q.push_back(make_exp(rd, addr, wd, tag));
        resp_word = rsp;
        host_write(2'd1, addr);
        host_write(2'd2, wd[7:0]);
        host_write(2'd3, wd[15:8]);
        host_write(2'd0, ctrl);
        start_cyc = cyc;
    endtask

    task automatic finish_txn(input int start_cyc, input int frames_before, input bit rd,
                              input logic [15:0] rsp);
        logic [7:0] v;
        logic [7:0] lo, hi;
        host_read(2'd0, v);
        while (v[0] == 1'b1) host_read(2'd0, v);
        check((cyc - start_cyc) == TXN_CYC, "R7 busy duration", 64'(cyc - start_cyc), 64'(TXN_CYC));
        check(frames_seen == frames_before + 1, "R8 one frame per start",
              64'(frames_seen), 64'(frames_before + 1));
        if (rd) begin
            host_read(2'd2, lo);
            host_read(2'd3, hi);
            check({hi, lo} == rsp, "R6 read result", {48'h0, hi, lo}, {48'h0, rsp});
        end
        host_write(2'd0, 8'h00);
        host_read(2'd0, v);
        check(v == 8'h00, "R2 control cleared", 64'(v), 64'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog expired", 64'(cyc), 64'h0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int sc, fb;
        repeat (4) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1: reset state
        for (int i = 0; i < 4; i++) begin
            host_read(2'(i), v);
            check(v == 8'h00, "R1 register reset", 64'(v), 64'h0);
        end
        check(mdc == 1'b0 && mdio_oe == 1'b0, "R1 pins idle", {62'h0, mdc, mdio_oe}, 64'h0);

        // R2: readback
        host_write(2'd1, 8'hC5);
        host_read(2'd1, v);
        check(v == 8'hC5, "R2 address readback", 64'(v), 64'hC5);
        host_write(2'd2, 8'h3C);
        host_read(2'd2, v);
        check(v == 8'h3C, "R2 data low readback", 64'(v), 64'h3C);
        host_write(2'd3, 8'hA9);
        host_read(2'd3, v);
        check(v == 8'hA9, "R2 data high readback", 64'(v), 64'hA9);

        // R3/R4: writes with several field patterns
        fb = frames_seen;
        start_txn(1'b0, 8'h41, 16'hBEEF, 16'h0, 8'h0A, "R4 write A", sc);
        host_read(2'd0, v);
        check(v == 8'h0B, "R2 control while busy", 64'(v), 64'h0B);
        finish_txn(sc, fb, 1'b0, 16'h0);

        fb = frames_seen;
        start_txn(1'b0, 8'hE5, 16'h1234, 16'h0, 8'h0A, "R4 write bit5 dropped", sc);
        finish_txn(sc, fb, 1'b0, 16'h0);

        fb = frames_seen;
        start_txn(1'b0, 8'h9F, 16'h8001, 16'h0, 8'h0A, "R3 write C", sc);
        finish_txn(sc, fb, 1'b0, 16'h0);

        // R5/R6: reads
        fb = frames_seen;
        start_txn(1'b1, 8'h42, 16'h0000, 16'hA55A, 8'h0C, "R5 read A", sc);
        finish_txn(sc, fb, 1'b1, 16'hA55A);

        fb = frames_seen;
        start_txn(1'b1, 8'hC1, 16'h0000, 16'h7E81, 8'h0C, "R5 read B", sc);
        finish_txn(sc, fb, 1'b1, 16'h7E81);

        // R11: both request bits set performs a read
        fb = frames_seen;
        start_txn(1'b1, 8'h03, 16'h0000, 16'h0F0F, 8'h0E, "R11 read priority", sc);
        finish_txn(sc, fb, 1'b1, 16'h0F0F);

        // R8: control write during busy ignored
        fb = frames_seen;
        start_txn(1'b0, 8'h85, 16'hC3C3, 16'h0, 8'h0A, "R8 write with poke", sc);
        repeat (20) @(negedge clk);
        host_write(2'd0, 8'h0C);
        host_read(2'd0, v);
        check(v == 8'h0B, "R8 control unchanged while busy", 64'(v), 64'h0B);
        finish_txn(sc, fb, 1'b0, 16'h0);

        // R9: other target selected, nothing happens
        fb = total_rises;
        host_write(2'd0, 8'h04);
        host_read(2'd0, v);
        check(v == 8'h04, "R9 busy stays low", 64'(v), 64'h04);
        repeat (50) @(negedge clk);
        check(total_rises == fb && mdc == 1'b0, "R9 no mdc activity", 64'(total_rises), 64'(fb));
        host_write(2'd0, 8'h00);

        check(exp_q.size() == 0, "R3 all frames seen", 64'(exp_q.size()), 64'h0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule